// File: doc/BRIEF.md
# Predicated Vector Load Sequencer with First-Fault Tracking

This block carries out one contiguous, predicated vector load, one element at a time. A load is launched with a base address, an address offset (an index register or a small signed immediate), a governing predicate holding one bit per destination byte, a 4-bit data-type code and a fault-handling mode. For each active element it makes one read on a simple request/response memory port. It then zero- or sign-extends the returned value to the register element size and writes it into a destination vector image. Inactive elements are written with zero and cost no memory access.

The block holds a first-fault predicate (FFR) with one bit per vector byte. A dedicated input sets it to all ones, and it is always visible on an output. In first-fault mode, a fault on the first active element is raised as an exception. A fault on any later active element is absorbed instead: the FFR is cleared from that element's byte position to the end of the vector, the load stops, and destination bytes from that element onward keep the contents the destination had before the load. No-fault mode absorbs every fault in this way, the first one included. Normal mode raises an exception on any fault.

Top module: `vld_ff_seq`

## Requirements
- R1: The data-type code selects memory size, register size and extension: 0 b→b, 1 b→h zero, 2 b→w zero, 3 b→d zero, 4 w→d sign, 5 h→h, 6 h→w zero, 7 h→d zero, 8 h→d sign, 9 h→w sign, 10 w→w, 11 w→d zero, 12 b→d sign, 13 b→w sign, 14 b→h sign, 15 d→d. Here b/h/w/d are 1/2/4/8 bytes, and memory data is little-endian.
- R2: An element whose first byte position has its predicate bit set is active and gets one memory read. An inactive element gets no read, and its destination bytes are written with zero.
- R3: Successive elements advance the memory address by the memory element size and the destination byte position by the register element size.
- R4: With form=0 (register offset), the first address is base + (index << log2(memory size)).
- R5: With form=1 (immediate), the first address is base + ((imm × (VLEN_BYTES >> log2(register size))) << log2(memory size)), where imm is a signed 4-bit value.
- R6: In first-fault mode (mode=1), a fault on the first active element pulses exception together with done and leaves the FFR unchanged.
- R7: In first-fault mode, a fault on a later active element at byte position i clears FFR bits i to VLEN_BYTES-1 and leaves the lower bits unchanged. No exception is raised. Destination bytes from i upward keep their pre-load contents.
- R8: In no-fault mode (mode=2), a fault on any active element, the first included, is recorded as in R7 and never raises exception.
- R9: In normal mode (mode=0 or 3), any fault pulses exception with done. The FFR is unchanged, and destination bytes from the faulting element upward keep their pre-load contents.
- R10: A load without a fault leaves the FFR unchanged. Asserting ffr_init sets every FFR bit to one, and reset does the same.
- R11: When ffr_init coincides with the cycle in which a fault is recorded, the FFR ends with bits below i set and bits from i upward clear.
- R12: start is taken only while busy is low, and the operands are captured at that moment. busy stays high until done, which is a one-cycle pulse. exception is only ever high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a load when idle |
| mode | input | 2 | 0 normal, 1 first-fault, 2 no-fault, 3 normal |
| form | input | 1 | 0 register offset, 1 immediate offset |
| dtype | input | 4 | Data-type code (R1) |
| base | input | ADDR_W | Base address |
| index | input | ADDR_W | Offset register value for form 0 |
| imm | input | 4 | Signed offset multiplier for form 1 |
| pred | input | VLEN_BYTES | Governing predicate, one bit per byte |
| dest_in | input | VLEN_BYTES*8 | Destination contents before the load |
| ffr_init | input | 1 | Set the FFR to all ones |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| exception | output | 1 | Trapping fault, pulses with done |
| dest_out | output | VLEN_BYTES*8 | Destination image |
| ffr | output | VLEN_BYTES | First-fault predicate |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | ADDR_W | Read address |
| mem_size | output | 2 | log2 of the access size in bytes |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read data, byte 0 at mem_addr |
| mem_fault | input | 1 | The acknowledged read faulted |

## Verification
Two things can update the FFR in the same cycle: the software-style ffr_init set, and the clearing done when a later-element fault is recorded. The bench first clears most of the FFR with a no-fault load. It then runs a first-fault load that faults at byte 12, and raises ffr_init exactly in the cycle where the faulting request is acknowledged. The check passes only if the FFR shows ones below byte 12 and zeros from byte 12 up. That result differs both from what the init alone would give and from what the clear alone would give.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_FIRST   = 2'd1,
        MODE_NOFAULT = 2'd2,
        MODE_RSV     = 2'd3
    } ld_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;

    // msz / esz are log2 of memory / register element size in bytes
    typedef struct packed {
        logic [1:0] msz;
        logic [1:0] esz;
        logic       sgn;
    } dt_info_t;

    function automatic dt_info_t decode_dtype(input logic [3:0] code);
        dt_info_t r;
        case (code)
            4'd0:    r = '{msz: 2'd0, esz: 2'd0, sgn: 1'b0};
            4'd1:    r = '{msz: 2'd0, esz: 2'd1, sgn: 1'b0};
            4'd2:    r = '{msz: 2'd0, esz: 2'd2, sgn: 1'b0};
            4'd3:    r = '{msz: 2'd0, esz: 2'd3, sgn: 1'b0};
            4'd4:    r = '{msz: 2'd2, esz: 2'd3, sgn: 1'b1};
            4'd5:    r = '{msz: 2'd1, esz: 2'd1, sgn: 1'b0};
            4'd6:    r = '{msz: 2'd1, esz: 2'd2, sgn: 1'b0};
            4'd7:    r = '{msz: 2'd1, esz: 2'd3, sgn: 1'b0};
            4'd8:    r = '{msz: 2'd1, esz: 2'd3, sgn: 1'b1};
            4'd9:    r = '{msz: 2'd1, esz: 2'd2, sgn: 1'b1};
            4'd10:   r = '{msz: 2'd2, esz: 2'd2, sgn: 1'b0};
            4'd11:   r = '{msz: 2'd2, esz: 2'd3, sgn: 1'b0};
            4'd12:   r = '{msz: 2'd0, esz: 2'd3, sgn: 1'b1};
            4'd13:   r = '{msz: 2'd0, esz: 2'd2, sgn: 1'b1};
            4'd14:   r = '{msz: 2'd0, esz: 2'd1, sgn: 1'b1};
            default: r = '{msz: 2'd3, esz: 2'd3, sgn: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vld_dtype_decode.sv
module vld_dtype_decode
    import vld_pkg::*;
(
    input  logic [3:0] dtype,
    output dt_info_t   info
);
    always_comb begin
        info = decode_dtype(dtype);
    end
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen
    import vld_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int VLEN_BYTES = 32
) (
    input  logic              form,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [3:0]        imm,
    input  dt_info_t          info,
    output logic [ADDR_W-1:0] start_addr
);
    localparam logic [ADDR_W-1:0] VL_W = ADDR_W'(VLEN_BYTES);

    logic [ADDR_W-1:0] elems;
    logic [ADDR_W-1:0] imm_sx;
    logic [ADDR_W-1:0] prod;
    logic [ADDR_W-1:0] reg_off;
    logic [ADDR_W-1:0] imm_off;

    always_comb begin
        elems   = VL_W >> info.esz;
        imm_sx  = {{(ADDR_W-4){imm[3]}}, imm};
        prod    = imm_sx * elems;
        imm_off = prod << info.msz;
        reg_off = index << info.msz;
        start_addr = base + (form ? imm_off : reg_off);
    end
endmodule

// File: rtl/vld_widen.sv
module vld_widen
    import vld_pkg::*;
(
    input  logic [63:0] raw,
    input  dt_info_t    info,
    output logic [63:0] ext
);
    logic [63:0] keep;
    logic        msb;

    always_comb begin
        case (info.msz)
            2'd0:    begin keep = 64'h0000_0000_0000_00FF; msb = raw[7];  end
            2'd1:    begin keep = 64'h0000_0000_0000_FFFF; msb = raw[15]; end
            2'd2:    begin keep = 64'h0000_0000_FFFF_FFFF; msb = raw[31]; end
            default: begin keep = 64'hFFFF_FFFF_FFFF_FFFF; msb = raw[63]; end
        endcase
        ext = raw & keep;
        if (info.sgn && msb) begin
            ext = ext | ~keep;
        end
    end
endmodule

// File: rtl/vld_ff_seq.sv
module vld_ff_seq
    import vld_pkg::*;
#(
    parameter int VLEN_BYTES = 32,
    parameter int ADDR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              mode,
    input  logic                    form,
    input  logic [3:0]              dtype,
    input  logic [ADDR_W-1:0]       base,
    input  logic [ADDR_W-1:0]       index,
    input  logic [3:0]              imm,
    input  logic [VLEN_BYTES-1:0]   pred,
    input  logic [VLEN_BYTES*8-1:0] dest_in,
    input  logic                    ffr_init,
    output logic                    busy,
    output logic                    done,
    output logic                    exception,
    output logic [VLEN_BYTES*8-1:0] dest_out,
    output logic [VLEN_BYTES-1:0]   ffr,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [1:0]              mem_size,
    input  logic                    mem_ack,
    input  logic [63:0]             mem_rdata,
    input  logic                    mem_fault
);
    localparam int VBITS = VLEN_BYTES * 8;
    localparam int LOG_VL = $clog2(VLEN_BYTES);
    localparam int IDX_W = LOG_VL + 1;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(VLEN_BYTES);

    typedef struct packed {
        seq_st_e               st;
        logic [IDX_W-1:0]      idx;
        logic [ADDR_W-1:0]     addr;
        logic                  first;
        ld_mode_e              mode;
        dt_info_t              info;
        logic [VLEN_BYTES-1:0] pred;
        logic [VBITS-1:0]      dest;
        logic [VLEN_BYTES-1:0] ffr;
        logic                  done;
        logic                  exc;
    } seq_t;

    seq_t cur_q, nxt_d;

    dt_info_t              dec_info;
    logic [ADDR_W-1:0]     start_addr;
    logic [63:0]           ext_val;
    logic [VLEN_BYTES-1:0] clr_mask;

    vld_dtype_decode u_dec (
        .dtype (dtype),
        .info  (dec_info)
    );

    vld_addr_gen #(
        .ADDR_W     (ADDR_W),
        .VLEN_BYTES (VLEN_BYTES)
    ) u_agen (
        .form       (form),
        .base       (base),
        .index      (index),
        .imm        (imm),
        .info       (dec_info),
        .start_addr (start_addr)
    );

    vld_widen u_widen (
        .raw  (mem_rdata),
        .info (cur_q.info),
        .ext  (ext_val)
    );

    // FFR bits at or above the current element's byte position
    for (genvar g = 0; g < VLEN_BYTES; g++) begin : g_clr
        assign clr_mask[g] = (IDX_W'(g) >= cur_q.idx);
    end

    always_comb begin
        int unsigned ebytes;
        int unsigned lo;
        logic        wr_en;
        logic [63:0] wr_val;
        logic        trap;

        nxt_d   = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.exc  = 1'b0;
        ebytes  = 32'd1 << cur_q.info.esz;
        lo      = 32'(cur_q.idx);
        wr_en   = 1'b0;
        wr_val  = '0;
        trap    = (cur_q.mode == MODE_NORMAL) || (cur_q.mode == MODE_RSV) ||
                  ((cur_q.mode == MODE_FIRST) && cur_q.first);

        if (ffr_init) begin
            nxt_d.ffr = '1;
        end

        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st    = ST_SCAN;
                    nxt_d.idx   = '0;
                    nxt_d.addr  = start_addr;
                    nxt_d.first = 1'b1;
                    nxt_d.mode  = ld_mode_e'(mode);
                    nxt_d.info  = dec_info;
                    nxt_d.pred  = pred;
                    nxt_d.dest  = dest_in;
                end
            end
            ST_SCAN: begin
                if (cur_q.idx >= IDX_END) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.done = 1'b1;
                end else if (cur_q.pred[cur_q.idx[LOG_VL-1:0]]) begin
                    nxt_d.st = ST_WAIT;
                end else begin
                    wr_en      = 1'b1;
                    wr_val     = '0;
                    nxt_d.idx  = cur_q.idx + (IDX_W'(1) << cur_q.info.esz);
                    nxt_d.addr = cur_q.addr + (ADDR_W'(1) << cur_q.info.msz);
                end
            end
            ST_WAIT: begin
                if (mem_ack) begin
                    if (!mem_fault) begin
                        wr_en       = 1'b1;
                        wr_val      = ext_val;
                        nxt_d.first = 1'b0;
                        nxt_d.st    = ST_SCAN;
                        nxt_d.idx   = cur_q.idx + (IDX_W'(1) << cur_q.info.esz);
                        nxt_d.addr  = cur_q.addr + (ADDR_W'(1) << cur_q.info.msz);
                    end else begin
                        nxt_d.st   = ST_IDLE;
                        nxt_d.done = 1'b1;
                        if (trap) begin
                            nxt_d.exc = 1'b1;
                        end else begin
                            nxt_d.ffr = nxt_d.ffr & ~clr_mask;
                        end
                    end
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase

        if (wr_en) begin
            for (int b = 0; b < 8; b++) begin
                if ((b < ebytes) && ((lo + b) < VLEN_BYTES)) begin
                    nxt_d.dest[(lo + b) * 8 +: 8] = wr_val[b * 8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.ffr <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy      = (cur_q.st != ST_IDLE);
    assign done      = cur_q.done;
    assign exception = cur_q.exc;
    assign dest_out  = cur_q.dest;
    assign ffr       = cur_q.ffr;
    assign mem_req   = (cur_q.st == ST_WAIT);
    assign mem_addr  = cur_q.addr;
    assign mem_size  = cur_q.info.msz;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exception |-> done);

    // R2
    req_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cur_q.pred[cur_q.idx[LOG_VL-1:0]]);

    // R10
    ffr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ffr_init && !(mem_req && mem_ack && mem_fault)) |=> $stable(ffr));

    // R6
    ff_first_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault && !ffr_init &&
         cur_q.mode == MODE_FIRST && cur_q.first) |=> (exception && $stable(ffr)));

    // R8
    nf_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault && cur_q.mode == MODE_NOFAULT)
        |=> (done && !exception));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/vld_ff_seq_tb.sv
module vld_ff_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 32;
    localparam logic [255:0] PREV = {8{32'hC3A5_5AE7}};

    typedef struct packed {
        logic [1:0]  mode;
        logic        form;
        logic [3:0]  dtype;
        logic [31:0] base;
        logic [31:0] index;
        logic [3:0]  imm;
        logic [31:0] pred;
        logic [31:0] flo;
        logic [31:0] fhi;
        logic        init_before;
    } tv_t;

    localparam int NV = 18;
    localparam tv_t TBL [NV] = '{
        '{2'd0, 1'b0, 4'd0,  32'h100, 32'h0, 4'h0, 32'hFFFF_FFFF, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd14, 32'h180, 32'h4, 4'h0, 32'h5555_5555, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd1,  32'h1C0, 32'h3, 4'h0, 32'h3333_3333, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b1, 4'd8,  32'h400, 32'h0, 4'hE, 32'h0101_0101, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b1, 4'd4,  32'h200, 32'h0, 4'h3, 32'h0100_0001, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd15, 32'h240, 32'h2, 4'h0, 32'hFFFF_FFFF, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd13, 32'h2A0, 32'h1, 4'h0, 32'h1111_1111, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd9,  32'h2C0, 32'h0, 4'h0, 32'hFFFF_FFFF, 32'h0,   32'h0,   1'b0},
        '{2'd1, 1'b0, 4'd10, 32'h300, 32'h0, 4'h0, 32'hFFFF_FFFF, 32'h308, 32'h400, 1'b1},
        '{2'd1, 1'b0, 4'd10, 32'h300, 32'h0, 4'h0, 32'hFFFF_FFF0, 32'h304, 32'h400, 1'b1},
        '{2'd2, 1'b0, 4'd10, 32'h300, 32'h0, 4'h0, 32'hFFFF_FFF0, 32'h304, 32'h400, 1'b1},
        '{2'd0, 1'b0, 4'd6,  32'h340, 32'h0, 4'h0, 32'hFFFF_FFFF, 32'h348, 32'h400, 1'b0},
        '{2'd2, 1'b1, 4'd7,  32'h500, 32'h0, 4'h1, 32'hFFFF_FFFF, 32'h50C, 32'h600, 1'b1},
        '{2'd1, 1'b0, 4'd11, 32'h600, 32'h1, 4'h0, 32'hFFFF_FFFF, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd12, 32'h700, 32'h0, 4'h0, 32'h0101_0101, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd5,  32'h720, 32'h3, 4'h0, 32'hFFFF_FFFF, 32'h0,   32'h0,   1'b0},
        '{2'd0, 1'b0, 4'd2,  32'h740, 32'h0, 4'h0, 32'h1111_0111, 32'h0,   32'h0,   1'b0},
        '{2'd3, 1'b0, 4'd3,  32'h760, 32'h0, 4'h0, 32'h0101_0001, 32'h0,   32'h0,   1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode_i = '0;
    logic         form_i = 1'b0;
    logic [3:0]   dtype_i = '0;
    logic [31:0]  base_i = '0;
    logic [31:0]  index_i = '0;
    logic [3:0]   imm_i = '0;
    logic [31:0]  pred_i = '0;
    logic [255:0] dest_i = PREV;
    logic         ffr_init = 1'b0;
    logic         busy, done, exception;
    logic [255:0] dest_out;
    logic [31:0]  ffr;
    logic         mem_req, mem_ack, mem_fault;
    logic [31:0]  mem_addr;
    logic [1:0]   mem_size;
    logic [63:0]  mem_rdata;
    logic [31:0]  flo = '0;
    logic [31:0]  fhi = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] ffr_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    vld_ff_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i), .form(form_i),
        .dtype(dtype_i), .base(base_i), .index(index_i), .imm(imm_i),
        .pred(pred_i), .dest_in(dest_i), .ffr_init(ffr_init),
        .busy(busy), .done(done), .exception(exception), .dest_out(dest_out),
        .ffr(ffr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5B;
    endfunction

    // memory model: answers in the same cycle
    always_comb begin
        mem_ack   = mem_req;
        mem_fault = mem_req && (mem_addr >= flo) && (mem_addr < fhi);
        for (int k = 0; k < 8; k++) mem_rdata[k*8 +: 8] = mbyte(mem_addr + 32'(k));
    end

    function automatic string vec_req(input int k);
        case (k)
            0, 5:        return "R1/R3/R4";
            1, 2, 6, 16: return "R1/R2/R3";
            3, 4:        return "R1/R5";
            8:           return "R7";
            9:           return "R6";
            10, 12:      return "R8";
            11, 17:      return "R9/R1";
            13:          return "R10";
            default:     return "R1/R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input tv_t v, input logic [255:0] prev,
                         output logic [255:0] de, output bit ee);
        int m, e, mb, eb;
        bit s, first;
        logic [31:0] a;
        logic [63:0] raw, keep;
        case (v.dtype)
            4'd0: begin m=0; e=0; s=0; end   4'd1: begin m=0; e=1; s=0; end
            4'd2: begin m=0; e=2; s=0; end   4'd3: begin m=0; e=3; s=0; end
            4'd4: begin m=2; e=3; s=1; end   4'd5: begin m=1; e=1; s=0; end
            4'd6: begin m=1; e=2; s=0; end   4'd7: begin m=1; e=3; s=0; end
            4'd8: begin m=1; e=3; s=1; end   4'd9: begin m=1; e=2; s=1; end
            4'd10: begin m=2; e=2; s=0; end  4'd11: begin m=2; e=3; s=0; end
            4'd12: begin m=0; e=3; s=1; end  4'd13: begin m=0; e=2; s=1; end
            4'd14: begin m=0; e=1; s=1; end  default: begin m=3; e=3; s=0; end
        endcase
        mb = 1 << m;
        eb = 1 << e;
        if (!v.form) a = v.base + (v.index << m);
        else a = v.base + 32'((int'($signed(v.imm)) * (VL >> e)) << m);
        de = prev;
        ee = 0;
        first = 1;
        for (int i = 0; i < VL; i += eb) begin
            if (v.pred[i]) begin
                if (a >= v.flo && a < v.fhi) begin
                    if (v.mode == 2'd0 || v.mode == 2'd3 || (v.mode == 2'd1 && first)) ee = 1;
                    else for (int j = i; j < VL; j++) ffr_m[j] = 1'b0;
                    break;
                end
                raw = '0;
                for (int k = 0; k < mb; k++) raw[k*8 +: 8] = mbyte(a + 32'(k));
                keep = (mb == 8) ? '1 : ((64'd1 << (mb*8)) - 64'd1);
                if (s && raw[mb*8-1]) raw = raw | ~keep;
                for (int k = 0; k < eb; k++) de[(i+k)*8 +: 8] = raw[k*8 +: 8];
                first = 0;
            end else begin
                for (int k = 0; k < eb; k++) de[(i+k)*8 +: 8] = 8'h00;
            end
            a = a + 32'(mb);
        end
    endtask

    task automatic run(input tv_t v, input bit inj_init, input bit restart,
                       output bit exc_seen);
        int ncyc;
        if (v.init_before) begin
            @(negedge clk); ffr_init = 1'b1;
            @(negedge clk); ffr_init = 1'b0;
            ffr_m = '1;
        end
        @(negedge clk);
        mode_i = v.mode; form_i = v.form; dtype_i = v.dtype; base_i = v.base;
        index_i = v.index; imm_i = v.imm; pred_i = v.pred;
        flo = v.flo; fhi = v.fhi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            start = 1'b1; dtype_i = 4'd15; mode_i = 2'd2; base_i = 32'h900; pred_i = '0;
            @(negedge clk);
            start = 1'b0;
        end
        exc_seen = 0;
        ncyc = 0;
        while (!done && ncyc < 2000) begin
            if (exception) exc_seen = 1;
            ffr_init = inj_init && mem_req && mem_fault;
            @(negedge clk);
            ncyc++;
        end
        ffr_init = 1'b0;
        if (exception) exc_seen = 1;
        chk(ncyc < 2000, "R12", "done timeout", 256'(ncyc), 256'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] de;
        bit ee, es;
        tv_t t;
        ffr_m = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R10 / R12
        chk(!busy && !done && !exception && !mem_req, "R12", "reset outputs",
            256'({busy, done, exception, mem_req}), 256'd0);
        chk(ffr == '1, "R10", "reset ffr", 256'(ffr), 256'(32'hFFFF_FFFF));
        chk(dest_out == '0, "R12", "reset dest", dest_out, '0);

        for (int k = 0; k < NV; k++) begin
            run(TBL[k], 1'b0, 1'b0, es);
            model(TBL[k], PREV, de, ee);
            chk(dest_out == de, vec_req(k), $sformatf("vec %0d dest", k), dest_out, de);
            chk(ffr == ffr_m, vec_req(k), $sformatf("vec %0d ffr", k), 256'(ffr), 256'(ffr_m));
            chk(es == ee, vec_req(k), $sformatf("vec %0d exception", k), 256'(es), 256'(ee));
        end

        // R12: start while busy is ignored; done is a single pulse
        run(TBL[0], 1'b0, 1'b1, es);
        model(TBL[0], PREV, de, ee);
        chk(dest_out == de, "R12", "restart ignored dest", dest_out, de);
        @(negedge clk);
        chk(!done && !busy, "R12", "done one pulse", 256'({done, busy}), 256'd0);
        @(negedge clk);
        chk(!done && !exception, "R12", "no second done", 256'({done, exception}), 256'd0);

        // R11: ffr_init together with a recorded fault
        run(TBL[10], 1'b0, 1'b0, es);
        chk(ffr == 32'h0000_000F, "R8", "pre-clear ffr", 256'(ffr), 256'(32'h0000_000F));
        t = '{2'd1, 1'b0, 4'd10, 32'h300, 32'h0, 4'h0, 32'hFFFF_FFFF, 32'h30C, 32'h400, 1'b0};
        run(t, 1'b1, 1'b0, es);
        chk(ffr == 32'h0000_0FFF, "R11", "init+fault ffr", 256'(ffr), 256'(32'h0000_0FFF));
        chk(!es, "R11", "init+fault exception", 256'(es), 256'd0);

        // R10: ffr_init while idle restores all ones
        @(negedge clk); ffr_init = 1'b1;
        @(negedge clk); ffr_init = 1'b0;
        chk(ffr == '1, "R10", "idle init", 256'(ffr), 256'(32'hFFFF_FFFF));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule